// File: doc/BRIEF.md
# Streaming Blob Labeller with Plate-Box Selection

The block takes a binary image one pixel per valid cycle in raster order (left to right, top row first). It groups set pixels into blobs, using only the pixel to the left and the pixel above. For every blob it keeps a bounding rectangle in a small label table. Label 0 stands for background, so a pixel of value 0 never joins a blob. When the last pixel of a frame has been taken in, the block walks the table. It reports every rectangle whose width, height, area and width-to-height ratio match a plate shape.

Selection runs in two tiers. A tight test is tried over all labels first. A looser test is tried over all labels only when the tight test found nothing. Each reported box carries a tier flag. The walk ends with a one-cycle done strobe, together with a flag that is set when no box qualified. If the label table runs out of entries, new blobs are dropped and a sticky flag records this until the next frame starts.

The block feeds a later stage that crops a plate from the greyscale frame. Image size, table depth and all geometry limits are parameters.

Top module: `ccl_plate_finder`

## Requirements
- R1: After reset, box_valid, sel_done, no_cand and overflow are all 0.
- R2: Each group of set pixels joined through left/upper adjacency gives one box holding its minimum and maximum x and y. x runs 0..IMG_W-1 from the pixel flagged with pix_sof, and y counts rows.
- R3: When a set pixel's left and upper neighbours carry different non-zero labels, the pixel takes the left label, and the left label's box grows to the union of both boxes and the pixel.
- R4: In the tight tier a box is reported with box_tier=0 when H is in 18..60, W is in 80..300, 3H <= W <= 7H and W*H >= 1600.
- R5: The loose tier (box_tier=1: H in 18..90, W in 36..300, 2H <= W <= 9H, W*H >= 648) runs only when the tight tier reported no box in that frame.
- R6: Loose-tier edges: H=17 is rejected, W=2H and W=9H are accepted, and W=2H-1 and W=9H+1 are rejected.
- R7: sel_done is a one-cycle pulse at the end of selection. no_cand is 1 from that pulse until the next pix_sof when no box was reported, and 0 otherwise.
- R8: When all LBL_N labels are in use, a pixel that would start a new blob gets label 0 and sets overflow. overflow stays set until the next pix_sof pixel clears it.
- R9: Boxes come out at most one per cycle, in ascending label order, which is the raster order of each blob's first pixel. sel_done arrives 1+LBL_N clock edges after the edge that takes the pix_eof pixel when the tight tier found a box, and 1+2*LBL_N edges after it otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pix_valid | input | 1 | Pixel present this cycle |
| pix_bit | input | 1 | Binary pixel value |
| pix_sof | input | 1 | First pixel of a frame |
| pix_eof | input | 1 | Last pixel of a frame |
| box_valid | output | 1 | Reported box this cycle |
| box_tier | output | 1 | 0 tight tier, 1 loose tier |
| box_xmin | output | $clog2(IMG_W) | Left column of box |
| box_xmax | output | $clog2(IMG_W) | Right column of box |
| box_ymin | output | $clog2(IMG_H) | Top row of box |
| box_ymax | output | $clog2(IMG_H) | Bottom row of box |
| sel_done | output | 1 | Selection finished (pulse) |
| no_cand | output | 1 | No box qualified in last frame |
| overflow | output | 1 | Label table ran out this frame |

## Verification
Labelling takes effect in the cycle each pixel is taken in. After the pix_eof pixel, the first table entry is judged at the second edge. A hit appears on box_valid one edge after its entry is judged, and sel_done follows the last entry of the final tier after 1+LBL_N or 1+2*LBL_N edges. The scoreboard queues the expected boxes for each frame and pops one every time box_valid is seen, so order and content are both checked. The driver counts falling edges from the pix_eof pixel to sel_done and compares that count with the cycle figure for the tier that ended the walk. no_cand and overflow are checked in the same cycle as sel_done.

// File: rtl/ccl_pkg.sv
package ccl_pkg;
   typedef enum logic [1:0] {
      SEL_IDLE   = 2'd0,
      SEL_STRICT = 2'd1,
      SEL_RELAX  = 2'd2
   } sel_state_e;

   localparam logic TIER_STRICT = 1'b0;
   localparam logic TIER_RELAX  = 1'b1;
endpackage

// File: rtl/ccl_label_core.sv
module ccl_label_core #(
   parameter int IMG_W = 640,
   parameter int IMG_H = 480,
   parameter int LBL_N = 15,
   localparam int XW = $clog2(IMG_W),
   localparam int YW = $clog2(IMG_H),
   localparam int LW = $clog2(LBL_N + 1),
   localparam int NE = 1 << LW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          pix_valid,
   input  logic          pix_bit,
   input  logic          pix_sof,
   input  logic          pix_eof,
   input  logic [LW-1:0] rd_idx,
   output logic          rd_live,
   output logic [XW-1:0] rd_xmin,
   output logic [XW-1:0] rd_xmax,
   output logic [YW-1:0] rd_ymin,
   output logic [YW-1:0] rd_ymax,
   output logic          frame_end,
   output logic          overflow
);
   logic [XW-1:0] x_q;
   logic [YW-1:0] y_q;
   logic [LW-1:0] left_q;
   logic [LW:0]   next_q;
   logic [LW-1:0] line_q [IMG_W];
   logic          live_q [NE];
   logic [XW-1:0] xmin_q [NE];
   logic [XW-1:0] xmax_q [NE];
   logic [YW-1:0] ymin_q [NE];
   logic [YW-1:0] ymax_q [NE];

   logic [XW-1:0] cur_x;
   logic [YW-1:0] cur_y;
   logic [LW-1:0] up, lf, lbl;
   logic [LW:0]   nxt;
   logic          full, alloc, merge, drop, take;
   logic [XW-1:0] nx0, nx1;
   logic [YW-1:0] ny0, ny1;

   assign take  = pix_valid;
   assign cur_x = pix_sof ? '0 : x_q;
   assign cur_y = pix_sof ? '0 : y_q;
   assign up    = (cur_y == '0) ? '0 : line_q[cur_x];
   assign lf    = (cur_x == '0) ? '0 : left_q;
   assign nxt   = pix_sof ? (LW+1)'(1) : next_q;
   assign full  = nxt > (LW+1)'(LBL_N);

   always_comb begin
      lbl = '0; alloc = 1'b0; merge = 1'b0; drop = 1'b0;
      if (pix_bit) begin
         if (lf != '0 && up != '0) begin
            lbl   = lf;
            merge = (lf != up);
         end else if (lf != '0) begin
            lbl = lf;
         end else if (up != '0) begin
            lbl = up;
         end else if (!full) begin
            lbl   = nxt[LW-1:0];
            alloc = 1'b1;
         end else begin
            drop = 1'b1;
         end
      end
   end

   always_comb begin
      nx0 = cur_x; nx1 = cur_x; ny0 = cur_y; ny1 = cur_y;
      if (!alloc) begin
         if (xmin_q[lbl] < nx0) nx0 = xmin_q[lbl];
         if (xmax_q[lbl] > nx1) nx1 = xmax_q[lbl];
         if (ymin_q[lbl] < ny0) ny0 = ymin_q[lbl];
         if (ymax_q[lbl] > ny1) ny1 = ymax_q[lbl];
      end
      if (merge) begin
         if (xmin_q[up] < nx0) nx0 = xmin_q[up];
         if (xmax_q[up] > nx1) nx1 = xmax_q[up];
         if (ymin_q[up] < ny0) ny0 = ymin_q[up];
         if (ymax_q[up] > ny1) ny1 = ymax_q[up];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         x_q       <= '0;
         y_q       <= '0;
         left_q    <= '0;
         next_q    <= (LW+1)'(1);
         frame_end <= 1'b0;
         overflow  <= 1'b0;
      end else begin
         frame_end <= take && pix_eof;
         if (take) begin
            if (cur_x == XW'(IMG_W - 1)) begin
               x_q <= '0;
               y_q <= cur_y + 1'b1;
            end else begin
               x_q <= cur_x + 1'b1;
               y_q <= cur_y;
            end
            left_q   <= lbl;
            next_q   <= alloc ? nxt + 1'b1 : nxt;
            overflow <= (pix_sof ? 1'b0 : overflow) | drop;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (take) line_q[cur_x] <= lbl;
   end

   generate
      for (genvar e = 0; e < NE; e++) begin : g_entry
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               live_q[e] <= 1'b0;
               xmin_q[e] <= '0;
               xmax_q[e] <= '0;
               ymin_q[e] <= '0;
               ymax_q[e] <= '0;
            end else if (take) begin
               if (lbl != '0 && lbl == LW'(e)) begin
                  live_q[e] <= 1'b1;
                  xmin_q[e] <= nx0;
                  xmax_q[e] <= nx1;
                  ymin_q[e] <= ny0;
                  ymax_q[e] <= ny1;
               end else if (pix_sof) begin
                  live_q[e] <= 1'b0;
               end
            end
         end
      end
   endgenerate

   assign rd_live = live_q[rd_idx];
   assign rd_xmin = xmin_q[rd_idx];
   assign rd_xmax = xmax_q[rd_idx];
   assign rd_ymin = ymin_q[rd_idx];
   assign rd_ymax = ymax_q[rd_idx];

   // R8
   ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (overflow && !(pix_valid && pix_sof)) |=> overflow);
   // R8
   ovf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid && pix_sof) |=> !overflow);
   // R2
   zero_pixel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid && !pix_bit && !pix_sof) |=> !overflow || $past(overflow));
endmodule

// File: rtl/ccl_box_select.sv
module ccl_box_select
   import ccl_pkg::*;
#(
   parameter int XW = 10,
   parameter int YW = 9,
   parameter int LW = 4,
   parameter int LBL_N = 15,
   parameter int STR_HMIN = 18, parameter int STR_HMAX = 60,
   parameter int STR_WMIN = 80, parameter int STR_WMAX = 300,
   parameter int STR_RMIN = 3,  parameter int STR_RMAX = 7,
   parameter int STR_AMIN = 1600,
   parameter int RLX_HMIN = 18, parameter int RLX_HMAX = 90,
   parameter int RLX_WMIN = 36, parameter int RLX_WMAX = 300,
   parameter int RLX_RMIN = 2,  parameter int RLX_RMAX = 9,
   parameter int RLX_AMIN = 648,
   parameter bit USE_AREA = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          frame_sof,
   output logic [LW-1:0] rd_idx,
   input  logic          rd_live,
   input  logic [XW-1:0] rd_xmin,
   input  logic [XW-1:0] rd_xmax,
   input  logic [YW-1:0] rd_ymin,
   input  logic [YW-1:0] rd_ymax,
   output logic          box_valid,
   output logic          box_tier,
   output logic [XW-1:0] box_xmin,
   output logic [XW-1:0] box_xmax,
   output logic [YW-1:0] box_ymin,
   output logic [YW-1:0] box_ymax,
   output logic          sel_done,
   output logic          no_cand
);
   sel_state_e    state_q;
   logic [LW-1:0] idx_q;
   logic          found_q, found_n, hit, str_ok, rlx_ok, str_area, rlx_area;
   logic          strict_seen_q;
   int            w, h;

   assign rd_idx = idx_q;
   assign w = int'(rd_xmax) - int'(rd_xmin) + 1;
   assign h = int'(rd_ymax) - int'(rd_ymin) + 1;

   generate
      if (USE_AREA) begin : g_area
         assign str_area = (w * h) >= STR_AMIN;
         assign rlx_area = (w * h) >= RLX_AMIN;
      end else begin : g_no_area
         assign str_area = 1'b1;
         assign rlx_area = 1'b1;
      end
   endgenerate

   assign str_ok = (h >= STR_HMIN) && (h <= STR_HMAX) && (w >= STR_WMIN) &&
                   (w <= STR_WMAX) && (w >= STR_RMIN * h) &&
                   (w <= STR_RMAX * h) && str_area;
   assign rlx_ok = (h >= RLX_HMIN) && (h <= RLX_HMAX) && (w >= RLX_WMIN) &&
                   (w <= RLX_WMAX) && (w >= RLX_RMIN * h) &&
                   (w <= RLX_RMAX * h) && rlx_area;
   assign hit = rd_live && (((state_q == SEL_STRICT) && str_ok) ||
                            ((state_q == SEL_RELAX) && rlx_ok));
   assign found_n = found_q | hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= SEL_IDLE;
         idx_q     <= LW'(1);
         found_q   <= 1'b0;
         box_valid <= 1'b0;
         box_tier  <= TIER_STRICT;
         box_xmin  <= '0;
         box_xmax  <= '0;
         box_ymin  <= '0;
         box_ymax  <= '0;
         sel_done  <= 1'b0;
         no_cand   <= 1'b0;
      end else begin
         box_valid <= 1'b0;
         sel_done  <= 1'b0;
         if (frame_sof) no_cand <= 1'b0;
         case (state_q)
            SEL_IDLE: if (start) begin
               state_q <= SEL_STRICT;
               idx_q   <= LW'(1);
               found_q <= 1'b0;
            end
            default: begin
               if (hit) begin
                  box_valid <= 1'b1;
                  box_tier  <= (state_q == SEL_RELAX) ? TIER_RELAX : TIER_STRICT;
                  box_xmin  <= rd_xmin;
                  box_xmax  <= rd_xmax;
                  box_ymin  <= rd_ymin;
                  box_ymax  <= rd_ymax;
               end
               found_q <= found_n;
               if (idx_q == LW'(LBL_N)) begin
                  idx_q <= LW'(1);
                  if (state_q == SEL_STRICT && !found_n) begin
                     state_q <= SEL_RELAX;
                  end else begin
                     state_q  <= SEL_IDLE;
                     sel_done <= 1'b1;
                     no_cand  <= !found_n;
                  end
               end else begin
                  idx_q <= idx_q + 1'b1;
               end
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) strict_seen_q <= 1'b0;
      else if (start && state_q == SEL_IDLE) strict_seen_q <= 1'b0;
      else if (box_valid && box_tier == TIER_STRICT) strict_seen_q <= 1'b1;
   end

   // R5
   relax_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (box_valid && box_tier == TIER_RELAX) |-> !strict_seen_q);
   // R7
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sel_done |=> !sel_done);
   // R7
   nocand_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_done && no_cand) |-> (!box_valid && !strict_seen_q));
   // R2
   box_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      box_valid |-> (box_xmin <= box_xmax && box_ymin <= box_ymax));
   // R4
   strict_height_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (box_valid && box_tier == TIER_STRICT) |->
      (int'(box_ymax) - int'(box_ymin) + 1 >= STR_HMIN));
endmodule

// File: rtl/ccl_plate_finder.sv
module ccl_plate_finder #(
   parameter int IMG_W = 640,
   parameter int IMG_H = 480,
   parameter int LBL_N = 15,
   parameter int STR_HMIN = 18, parameter int STR_HMAX = 60,
   parameter int STR_WMIN = 80, parameter int STR_WMAX = 300,
   parameter int STR_RMIN = 3,  parameter int STR_RMAX = 7,
   parameter int STR_AMIN = 1600,
   parameter int RLX_HMIN = 18, parameter int RLX_HMAX = 90,
   parameter int RLX_WMIN = 36, parameter int RLX_WMAX = 300,
   parameter int RLX_RMIN = 2,  parameter int RLX_RMAX = 9,
   parameter int RLX_AMIN = 648,
   parameter bit USE_AREA = 1'b1,
   localparam int XW = $clog2(IMG_W),
   localparam int YW = $clog2(IMG_H),
   localparam int LW = $clog2(LBL_N + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          pix_valid,
   input  logic          pix_bit,
   input  logic          pix_sof,
   input  logic          pix_eof,
   output logic          box_valid,
   output logic          box_tier,
   output logic [XW-1:0] box_xmin,
   output logic [XW-1:0] box_xmax,
   output logic [YW-1:0] box_ymin,
   output logic [YW-1:0] box_ymax,
   output logic          sel_done,
   output logic          no_cand,
   output logic          overflow
);
   generate
      if (IMG_W < 2 || IMG_H < 2) begin : g_bad_size
         $error("image must be at least 2x2");
      end
      if (LBL_N < 1) begin : g_bad_depth
         $error("label table needs at least one entry");
      end
      if (STR_HMIN < RLX_HMIN || STR_RMIN > STR_RMAX || RLX_RMIN > RLX_RMAX) begin : g_bad_geom
         $error("geometry limits inconsistent");
      end
   endgenerate

   logic [LW-1:0] rd_idx;
   logic          rd_live, frame_end;
   logic [XW-1:0] rd_xmin, rd_xmax;
   logic [YW-1:0] rd_ymin, rd_ymax;

   ccl_label_core #(.IMG_W(IMG_W), .IMG_H(IMG_H), .LBL_N(LBL_N)) u_core (
      .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_bit(pix_bit),
      .pix_sof(pix_sof), .pix_eof(pix_eof), .rd_idx(rd_idx),
      .rd_live(rd_live), .rd_xmin(rd_xmin), .rd_xmax(rd_xmax),
      .rd_ymin(rd_ymin), .rd_ymax(rd_ymax), .frame_end(frame_end),
      .overflow(overflow));

   ccl_box_select #(
      .XW(XW), .YW(YW), .LW(LW), .LBL_N(LBL_N),
      .STR_HMIN(STR_HMIN), .STR_HMAX(STR_HMAX), .STR_WMIN(STR_WMIN),
      .STR_WMAX(STR_WMAX), .STR_RMIN(STR_RMIN), .STR_RMAX(STR_RMAX),
      .STR_AMIN(STR_AMIN),
      .RLX_HMIN(RLX_HMIN), .RLX_HMAX(RLX_HMAX), .RLX_WMIN(RLX_WMIN),
      .RLX_WMAX(RLX_WMAX), .RLX_RMIN(RLX_RMIN), .RLX_RMAX(RLX_RMAX),
      .RLX_AMIN(RLX_AMIN), .USE_AREA(USE_AREA)
   ) u_sel (
      .clk(clk), .rst_n(rst_n), .start(frame_end),
      .frame_sof(pix_valid && pix_sof), .rd_idx(rd_idx),
      .rd_live(rd_live), .rd_xmin(rd_xmin), .rd_xmax(rd_xmax),
      .rd_ymin(rd_ymin), .rd_ymax(rd_ymax), .box_valid(box_valid),
      .box_tier(box_tier), .box_xmin(box_xmin), .box_xmax(box_xmax),
      .box_ymin(box_ymin), .box_ymax(box_ymax), .sel_done(sel_done),
      .no_cand(no_cand));
endmodule

// File: tb/ccl_plate_finder_bench.sv
`timescale 1ns/1ps
module ccl_plate_finder_bench;
   localparam int IMG_W = 200;
   localparam int IMG_H = 24;
   localparam int LBL_N = 4;
   localparam int XW = $clog2(IMG_W);
   localparam int YW = $clog2(IMG_H);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pix_valid = 1'b0, pix_bit = 1'b0, pix_sof = 1'b0, pix_eof = 1'b0;
   logic box_valid, box_tier, sel_done, no_cand, overflow;
   logic [XW-1:0] box_xmin, box_xmax;
   logic [YW-1:0] box_ymin, box_ymax;

   always #10 clk = ~clk;

   ccl_plate_finder #(.IMG_W(IMG_W), .IMG_H(IMG_H), .LBL_N(LBL_N)) u_ccl_plate_finder (
      .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_bit(pix_bit),
      .pix_sof(pix_sof), .pix_eof(pix_eof), .box_valid(box_valid),
      .box_tier(box_tier), .box_xmin(box_xmin), .box_xmax(box_xmax),
      .box_ymin(box_ymin), .box_ymax(box_ymax), .sel_done(sel_done),
      .no_cand(no_cand), .overflow(overflow));

   typedef struct { int x0; int x1; int y0; int y1; bit tier; } exp_t;
   exp_t exp_q[$];
   int   rx0[$], rx1[$], ry0[$], ry1[$];
   int   checks = 0, errors = 0;
   bit   exp_nocand, exp_ovf;
   string tag;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
      end
   endtask

   // monitor: scoreboard pop on each reported box
   always @(negedge clk) begin
      if (rst_n && box_valid) begin
         if (exp_q.size() == 0) begin
            check(1'b0, tag, "unexpected box xmin", int'(box_xmin), -1);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            check(int'(box_xmin) == e.x0 && int'(box_xmax) == e.x1 &&
                  int'(box_ymin) == e.y0 && int'(box_ymax) == e.y1,
                  tag, "box xmin*1e6+xmax*1e3+ymin",
                  int'(box_xmin)*1000000 + int'(box_xmax)*1000 + int'(box_ymin),
                  e.x0*1000000 + e.x1*1000 + e.y0);
            check(box_tier == e.tier, tag, "box tier", int'(box_tier), int'(e.tier));
         end
      end
   end

   function automatic bit pix_at(input int x, input int y);
      for (int i = 0; i < rx0.size(); i++)
         if (x >= rx0[i] && x <= rx1[i] && y >= ry0[i] && y <= ry1[i]) return 1'b1;
      return 1'b0;
   endfunction

   task automatic add_rect(input int x0, input int x1, input int y0, input int y1);
      rx0.push_back(x0); rx1.push_back(x1); ry0.push_back(y0); ry1.push_back(y1);
   endtask

   task automatic push_exp(input int x0, input int x1, input int y0, input int y1,
                           input bit tier);
      exp_t e;
      e.x0 = x0; e.x1 = x1; e.y0 = y0; e.y1 = y1; e.tier = tier;
      exp_q.push_back(e);
   endtask

   // driver: stream a frame then wait for the done strobe and time it
   task automatic run_frame(input string req, input bit strict_hit);
      int k;
      bit seen;
      tag = req;
      for (int y = 0; y < IMG_H; y++) begin
         for (int x = 0; x < IMG_W; x++) begin
            @(negedge clk);
            pix_valid = 1'b1;
            pix_bit   = pix_at(x, y);
            pix_sof   = (x == 0 && y == 0);
            pix_eof   = (x == IMG_W-1 && y == IMG_H-1);
         end
      end
      k = 0; seen = 1'b0;
      while (!seen && k < 200) begin
         @(negedge clk);
         pix_valid = 1'b0; pix_bit = 1'b0; pix_sof = 1'b0; pix_eof = 1'b0;
         k++;
         if (sel_done) seen = 1'b1;
      end
      // R9 latency from the eof pixel to the done strobe
      check(seen && k == (strict_hit ? 2 + LBL_N : 2 + 2*LBL_N), "R9",
            "done latency", k, strict_hit ? 2 + LBL_N : 2 + 2*LBL_N);
      // R7 no-candidate flag with done
      check(no_cand == exp_nocand, "R7", "no_cand", int'(no_cand), int'(exp_nocand));
      check(overflow == exp_ovf, "R8", "overflow", int'(overflow), int'(exp_ovf));
      check(exp_q.size() == 0, req, "missing boxes", exp_q.size(), 0);
      exp_q.delete();
      @(negedge clk);
      check(!sel_done, "R7", "done single pulse", int'(sel_done), 0);
      check(no_cand == exp_nocand, "R7", "no_cand held", int'(no_cand), int'(exp_nocand));
      rx0.delete(); rx1.delete(); ry0.delete(); ry1.delete();
   endtask

   initial begin
      #(200000 * 20);
      errors++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check(!box_valid && !sel_done && !no_cand && !overflow, "R1", "reset outputs",
            int'({box_valid, sel_done, no_cand, overflow}), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R2 R4 single tight box
      add_rect(10, 109, 2, 21); push_exp(10, 109, 2, 21, 1'b0);
      exp_nocand = 0; exp_ovf = 0; run_frame("R4", 1'b1);

      // R5 tight box present, loose-only box suppressed
      add_rect(5, 104, 1, 20); add_rect(150, 189, 1, 20);
      push_exp(5, 104, 1, 20, 1'b0);
      exp_nocand = 0; run_frame("R5", 1'b1);

      // R5 loose-only box reported with tier 1
      add_rect(150, 189, 1, 20); push_exp(150, 189, 1, 20, 1'b1);
      exp_nocand = 0; run_frame("R5", 1'b0);

      // R6 W=2H, H=18
      add_rect(3, 38, 3, 20); push_exp(3, 38, 3, 20, 1'b1);
      exp_nocand = 0; run_frame("R6", 1'b0);

      // R6 W=9H
      add_rect(20, 181, 4, 21); push_exp(20, 181, 4, 21, 1'b1);
      exp_nocand = 0; run_frame("R6", 1'b0);

      // R6 W=9H+1 rejected
      add_rect(10, 172, 0, 17);
      exp_nocand = 1; run_frame("R6", 1'b0);

      // R6 W=2H-1 rejected
      add_rect(50, 88, 2, 21);
      exp_nocand = 1; run_frame("R6", 1'b0);

      // R6 H=17 rejected
      add_rect(10, 109, 3, 19);
      exp_nocand = 1; run_frame("R6", 1'b0);

      // R3 merge: two bars joined by a bottom band
      add_rect(10, 19, 2, 19); add_rect(80, 89, 2, 19); add_rect(10, 89, 20, 21);
      push_exp(10, 89, 2, 21, 1'b0);
      exp_nocand = 0; run_frame("R3", 1'b1);

      // R8 table full: fifth blob dropped
      add_rect(0, 1, 0, 1); add_rect(10, 11, 0, 1); add_rect(20, 21, 0, 1);
      add_rect(30, 31, 0, 1); add_rect(100, 159, 4, 21);
      exp_nocand = 1; exp_ovf = 1; run_frame("R8", 1'b0);

      // R8 overflow cleared by the next frame
      add_rect(10, 109, 2, 21); push_exp(10, 109, 2, 21, 1'b0);
      exp_nocand = 0; exp_ovf = 0; run_frame("R8", 1'b1);

      // R9 two tight boxes in raster order of first pixel
      add_rect(100, 189, 5, 22); add_rect(0, 89, 1, 18);
      push_exp(0, 89, 1, 18, 1'b0); push_exp(100, 189, 5, 22, 1'b0);
      exp_nocand = 0; run_frame("R9", 1'b1);

      // R7 empty frame
      exp_nocand = 1; run_frame("R7", 1'b0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule